// File: doc/BRIEF.md
# Receive Character Queue with Head-Entry Status

This block sits between a serial receiver and the bus side of a UART. It receives characters of 5 to 8 data bits from the receiver core. Each character comes with its own parity-error, framing-error and break flags. The block stores them in a first-in first-out queue, and each queue entry keeps one byte together with its three flags. Characters shorter than a byte have their unused upper bits forced to zero before they are stored.

The bus side sees the flags of the oldest stored character on a status output. It fetches that character with a data-read access. Software reads status first and data second. The status view does not move until the data read removes the head entry, so the two reads always describe the same character. The block also shows whether data is waiting, and it keeps a sticky overrun flag. That flag is set when a character arrives with no free space, and a status read clears it. A synchronous clear empties the queue and drops all flags.

Top module: `rxq_status_fifo`

## Requirements
- R1: Data reads return stored characters in the order they were pushed, oldest first.
- R2: Bit 0 of `push_data` is the earliest-received serial bit, and it appears unchanged at bit 0 of `rd_data`.
- R3: `push_len` selects the character length: 0 = 5 bits, 1 = 6 bits, 2 = 7 bits, 3 = 8 bits. Bits at and above that length read as zero in `rd_data`.
- R4: `head_pe`, `head_fe` and `head_bi` show the flags of the entry at the head of the queue, which is the entry the next data read returns. They are all zero when the queue is empty.
- R5: A status read does not advance the head. The head flags change only when a data read removes the head entry, a push fills an empty queue, or a clear occurs.
- R6: An access with `data_we` high is a write to the read-only data location. It leaves the queue contents, `rd_data` and every flag unchanged.
- R7: The queue holds DEPTH entries (16 by default). `data_ready` is high exactly when at least one entry is stored.
- R8: A push into a full queue with no data read in the same cycle sets `overrun` on the next cycle. The incoming character is discarded and the stored entries are kept.
- R9: `overrun` stays set until a status read. It clears in the cycle after `stat_rd`, unless a new overrun happens in that same cycle, in which case it stays set.
- R10: A data read while the queue is empty leaves `rd_data` holding its last value and changes no queue state.
- R11: `fifo_clr` empties the queue and clears `overrun` and `rd_data` on the next clock edge.
- R12: After reset the queue is empty and `rd_data`, `overrun`, `data_ready` and the head flags are all zero.
- R13: A data read returns the character in `rd_data` one cycle after the access, and in that same cycle the head flags move to the next entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_clr | input | 1 | Synchronous clear of queue and flags |
| push_valid | input | 1 | Receiver delivers one character this cycle |
| push_data | input | 8 | Received bits, bit 0 earliest |
| push_len | input | 2 | Character length code (0..3 = 5..8 bits) |
| push_pe | input | 1 | Parity error of the delivered character |
| push_fe | input | 1 | Framing error of the delivered character |
| push_bi | input | 1 | Break indication of the delivered character |
| data_acc | input | 1 | Bus access to the data location |
| data_we | input | 1 | Access is a write (ignored) |
| stat_rd | input | 1 | Bus read of the status view |
| rd_data | output | 8 | Last character fetched by a data read |
| head_pe | output | 1 | Parity error of head entry |
| head_fe | output | 1 | Framing error of head entry |
| head_bi | output | 1 | Break indication of head entry |
| data_ready | output | 1 | Queue holds at least one entry |
| overrun | output | 1 | Sticky overrun flag |

## Verification
Some properties are checked on every cycle. The head flags read zero whenever no data is waiting. An idle cycle or a status read leaves the head view unchanged. A write access has no effect. A read of an empty queue holds `rd_data`. Overrun sets on a push into a full queue, stays set until a status read, and clears after one. A clear empties the queue. Other behaviour shows only in the bench scenarios, which compare every cycle against a queue model: the order of characters after a wrap, the zero padding for each length code, the exact pairing of flags with each byte, and the loss of the character that overflows the queue.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int CHAR_W = 8;
    localparam int MIN_LEN = 5;

    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              par;
        logic [CHAR_W-1:0] data;
    } rxq_entry_t;
endpackage

// File: rtl/rxq_pad.sv
module rxq_pad
    import rxq_pkg::*;
(
    input  logic [CHAR_W-1:0] raw_char,
    input  logic [1:0]        len_code,
    output logic [CHAR_W-1:0] padded_char
);
    logic [3:0] bit_limit;
    assign bit_limit = 4'(MIN_LEN) + {2'b00, len_code};

    for (genvar gi = 0; gi < CHAR_W; gi++) begin : g_bit
        if (gi < MIN_LEN) begin : g_keep
            assign padded_char[gi] = raw_char[gi];
        end else begin : g_mask
            assign padded_char[gi] = raw_char[gi] & (4'(gi) < bit_limit);
        end
    end
endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       push,
    input  logic       pop,
    input  rxq_entry_t wr_entry,
    output rxq_entry_t head_entry,
    output logic [CW-1:0] level,
    output logic       full
);
    typedef struct packed {
        rxq_entry_t [DEPTH-1:0] mem;
        logic [PW-1:0]          wr_ptr;
        logic [PW-1:0]          rd_ptr;
        logic [CW-1:0]          cnt;
    } store_st_t;

    store_st_t st_d, st_q;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.cnt    = '0;
            st_d.mem    = '0;
        end else begin
            if (push) begin
                st_d.mem[st_q.wr_ptr] = wr_entry;
                st_d.wr_ptr           = ptr_next(st_q.wr_ptr);
            end
            if (pop) begin
                st_d.rd_ptr = ptr_next(st_q.rd_ptr);
            end
            case ({push, pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_entry = (st_q.cnt == '0) ? '0 : st_q.mem[st_q.rd_ptr];
    assign level      = st_q.cnt;
    assign full       = (st_q.cnt == CW'(DEPTH));
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
    import rxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              pop,
    input  logic [CHAR_W-1:0] head_data,
    input  logic              ovf_evt,
    input  logic              stat_rd,
    output logic [CHAR_W-1:0] rd_data,
    output logic              overrun
);
    typedef struct packed {
        logic [CHAR_W-1:0] rdat;
        logic              ovr;
    } flag_st_t;

    flag_st_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (clr) begin
            fl_d = '0;
        end else begin
            if (pop) fl_d.rdat = head_data;
            fl_d.ovr = ovf_evt | (fl_q.ovr & ~stat_rd);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign rd_data = fl_q.rdat;
    assign overrun = fl_q.ovr;
endmodule

// File: rtl/rxq_status_fifo.sv
module rxq_status_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_clr,
    input  logic              push_valid,
    input  logic [CHAR_W-1:0] push_data,
    input  logic [1:0]        push_len,
    input  logic              push_pe,
    input  logic              push_fe,
    input  logic              push_bi,
    input  logic              data_acc,
    input  logic              data_we,
    input  logic              stat_rd,
    output logic [CHAR_W-1:0] rd_data,
    output logic              head_pe,
    output logic              head_fe,
    output logic              head_bi,
    output logic              data_ready,
    output logic              overrun
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CHAR_W-1:0] padded;
    rxq_entry_t        new_entry, head_entry;
    logic [CW-1:0]     level;
    logic              fifo_full, rd_pop, wr_push, ovf_evt;

    rxq_pad u_pad (
        .raw_char    (push_data),
        .len_code    (push_len),
        .padded_char (padded)
    );

    assign new_entry = '{brk: push_bi, frm: push_fe, par: push_pe, data: padded};

    assign rd_pop  = data_acc & ~data_we & (level != '0);
    assign wr_push = push_valid & (~fifo_full | rd_pop);
    assign ovf_evt = push_valid & fifo_full & ~rd_pop;

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (fifo_clr),
        .push       (wr_push),
        .pop        (rd_pop),
        .wr_entry   (new_entry),
        .head_entry (head_entry),
        .level      (level),
        .full       (fifo_full)
    );

    rxq_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (fifo_clr),
        .pop       (rd_pop),
        .head_data (head_entry.data),
        .ovf_evt   (ovf_evt),
        .stat_rd   (stat_rd),
        .rd_data   (rd_data),
        .overrun   (overrun)
    );

    assign head_pe    = head_entry.par;
    assign head_fe    = head_entry.frm;
    assign head_bi    = head_entry.brk;
    assign data_ready = (level != '0);
endmodule

// File: rtl/rxq_status_fifo_chk.sv
module rxq_status_fifo_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_clr,
    input logic       push_valid,
    input logic       data_acc,
    input logic       data_we,
    input logic       stat_rd,
    input logic [7:0] rd_data,
    input logic       head_pe,
    input logic       head_fe,
    input logic       head_bi,
    input logic       data_ready,
    input logic       overrun,
    input logic       fifo_full,
    input logic       rd_pop
);
    // R4
    empty_flags_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_ready |-> ({head_bi, head_fe, head_pe} == 3'b000));

    // R5
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_valid && !(data_acc && !data_we) && !fifo_clr)
        |=> ($stable({head_bi, head_fe, head_pe}) && $stable(data_ready)));

    // R6
    write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && data_we && !push_valid && !fifo_clr)
        |=> ($stable(rd_data) && $stable(data_ready) && $stable({head_bi, head_fe, head_pe})));

    // R7
    ready_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !fifo_clr) |=> data_ready);

    // R8
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && fifo_full && !rd_pop && !fifo_clr) |=> overrun);

    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !stat_rd && !fifo_clr) |=> overrun);

    // R9
    overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !push_valid && !fifo_clr) |=> !overrun);

    // R10
    empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !data_we && !data_ready && !fifo_clr) |=> $stable(rd_data));

    // R11
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (!data_ready && !overrun && rd_data == 8'h00));
endmodule

bind rxq_status_fifo rxq_status_fifo_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_clr   (fifo_clr),
    .push_valid (push_valid),
    .data_acc   (data_acc),
    .data_we    (data_we),
    .stat_rd    (stat_rd),
    .rd_data    (rd_data),
    .head_pe    (head_pe),
    .head_fe    (head_fe),
    .head_bi    (head_bi),
    .data_ready (data_ready),
    .overrun    (overrun),
    .fifo_full  (fifo_full),
    .rd_pop     (rd_pop)
);

// File: tb/rxq_status_fifo_tb.sv
module rxq_status_fifo_tb;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_clr = 1'b0;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = '0;
    logic [1:0] push_len = '0;
    logic       push_pe = 1'b0, push_fe = 1'b0, push_bi = 1'b0;
    logic       data_acc = 1'b0, data_we = 1'b0, stat_rd = 1'b0;
    logic [7:0] rd_data;
    logic       head_pe, head_fe, head_bi, data_ready, overrun;

    always #4 clk = ~clk;

    rxq_status_fifo #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr),
        .push_valid(push_valid), .push_data(push_data), .push_len(push_len),
        .push_pe(push_pe), .push_fe(push_fe), .push_bi(push_bi),
        .data_acc(data_acc), .data_we(data_we), .stat_rd(stat_rd),
        .rd_data(rd_data), .head_pe(head_pe), .head_fe(head_fe), .head_bi(head_bi),
        .data_ready(data_ready), .overrun(overrun)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model: entry = {bi, fe, pe, data}
    logic [10:0] mq[$];
    logic [7:0]  m_rd = '0;
    logic        m_ovr = 1'b0;

    always @(posedge clk) begin
        if (!rst_n || fifo_clr) begin
            mq.delete();
            m_rd  = '0;
            m_ovr = 1'b0;
        end else begin
            automatic bit was_full = (mq.size() == DEPTH);
            automatic bit pop = data_acc && !data_we && (mq.size() > 0);
            automatic bit ovf = push_valid && was_full && !pop;
            automatic int keep = 5 + int'(push_len);
            automatic logic [7:0] pd = push_data & 8'((1 << keep) - 1);
            if (pop) begin
                m_rd = mq[0][7:0];
                void'(mq.pop_front());
            end
            if (push_valid && (!was_full || pop))
                mq.push_back({push_bi, push_fe, push_pe, pd});
            m_ovr = ovf || (m_ovr && !stat_rd);
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            automatic logic [2:0] ef = (mq.size() > 0) ? mq[0][10:8] : 3'b000;
            chk(rd_data == m_rd, "R1 R2 R3 R13", "rd_data", rd_data, m_rd);
            chk({head_bi, head_fe, head_pe} == ef, "R4 R5", "head flags",
                {head_bi, head_fe, head_pe}, ef);
            chk(data_ready == (mq.size() > 0), "R7", "data_ready", data_ready, mq.size() > 0);
            chk(overrun == m_ovr, "R8 R9", "overrun", overrun, m_ovr);
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
        push_valid = 0; data_acc = 0; data_we = 0; stat_rd = 0; fifo_clr = 0;
    endtask

    task automatic push_char(input logic [7:0] d, input logic [1:0] len, input logic [2:0] f);
        push_valid = 1; push_data = d; push_len = len;
        {push_bi, push_fe, push_pe} = f;
        tick();
    endtask

    task automatic read_data();
        data_acc = 1; data_we = 0;
        tick();
    endtask

    task automatic read_stat();
        stat_rd = 1;
        tick();
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #22 rst_n = 1;
        #10;
        // R12 reset state
        chk(rd_data == 0 && !data_ready && !overrun && {head_bi, head_fe, head_pe} == 0,
            "R12", "reset state", {rd_data, data_ready, overrun}, 0);

        // R2 R3 R4 R5: lengths and flags, status then data
        push_char(8'hFF, 2'd0, 3'b001);
        push_char(8'hFF, 2'd1, 3'b010);
        push_char(8'hFF, 2'd2, 3'b100);
        push_char(8'hA5, 2'd3, 3'b000);
        chk(head_pe == 1 && head_fe == 0, "R4", "head flags first", {head_bi, head_fe, head_pe}, 1);
        read_stat(); read_stat();
        chk({head_bi, head_fe, head_pe} == 3'b001, "R5", "status read holds head",
            {head_bi, head_fe, head_pe}, 1);
        read_data();
        chk(rd_data == 8'h1F, "R3", "5-bit pad", rd_data, 8'h1F);
        chk({head_bi, head_fe, head_pe} == 3'b010, "R13", "head advanced",
            {head_bi, head_fe, head_pe}, 2);
        read_data();
        chk(rd_data == 8'h3F, "R3", "6-bit pad", rd_data, 8'h3F);
        read_data();
        chk(rd_data == 8'h7F, "R3", "7-bit pad", rd_data, 8'h7F);

        // R6 write to data location
        data_acc = 1; data_we = 1; tick();
        chk(data_ready && rd_data == 8'h7F, "R6", "write ignored", rd_data, 8'h7F);
        read_data();
        chk(rd_data == 8'hA5, "R2", "8-bit order", rd_data, 8'hA5);

        // R10 read when empty
        read_data();
        chk(rd_data == 8'hA5 && !data_ready, "R10", "empty read holds", rd_data, 8'hA5);

        // R7 R8 fill and overflow
        for (int i = 0; i < DEPTH; i++) push_char(8'(i * 7 + 3), 2'd3, 3'(i));
        chk(data_ready && !overrun, "R7", "full no overrun", overrun, 0);
        push_char(8'hEE, 2'd3, 3'b111);
        chk(overrun == 1, "R8", "overrun set", overrun, 1);
        push_char(8'hDD, 2'd3, 3'b111);
        read_stat();
        chk(overrun == 0, "R9", "overrun cleared", overrun, 0);
        for (int i = 0; i < DEPTH; i++) begin
            read_data();
            chk(rd_data == 8'(i * 7 + 3), "R1", "drain order", rd_data, 8'(i * 7 + 3));
        end
        chk(!data_ready, "R8", "dropped char absent", data_ready, 0);

        // R9 set wins over status read
        for (int i = 0; i < DEPTH; i++) push_char(8'(i), 2'd3, 3'b000);
        push_valid = 1; push_data = 8'h55; stat_rd = 1; tick();
        chk(overrun == 1, "R9", "set beats clear", overrun, 1);
        // push while popping at full: accepted, no overrun
        read_stat();
        push_valid = 1; push_data = 8'h66; push_len = 2'd3; data_acc = 1; tick();
        chk(overrun == 0 && rd_data == 8'h00, "R8", "push with pop at full", rd_data, 0);

        // R11 clear
        fifo_clr = 1; tick();
        chk(!data_ready && rd_data == 0 && !overrun, "R11", "clear", {data_ready, rd_data}, 0);
        push_char(8'h3C, 2'd3, 3'b101);
        read_data();
        chk(rd_data == 8'h3C, "R11", "usable after clear", rd_data, 8'h3C);

        repeat (3) tick();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule